// File: doc/BRIEF.md
# Windowed Raster Readout Timing Generator

This block sequences the readout of a rectangular window cut from a larger pixel array. Each clock is one pixel slot. It produces a frame-valid and a line-valid strobe, the array row and column address of the pixel in each active slot, and the colour-filter phase of that pixel. The host programs the window origin and size, the horizontal blanking (in pixel slots) and the vertical blanking (in whole row periods). It can also mirror the scan in either direction.

Geometry and mirror settings are captured once per frame, during a single load slot that comes before the first row. A frame therefore always runs on one consistent set of values.

A host can resynchronize the raster with a one-cycle restart pulse. The row in progress and one further row run to completion, and then a fresh frame begins. If the pause input is high when that point is reached, the generator waits with both strobes low until the pause is released.

Top module: `rwin_timing`

## Requirements
- R1: While reset is asserted, frameValid, lineValid and restartBusy are all low.
- R2: Each active line holds lineValid high for exactly W = (cfgColSize with bit 0 forced to 1) + 1 consecutive cycles. lineValid is never high while frameValid is low.
- R3: Between two lines of one frame, lineValid is low for cfgHBlank cycles while frameValid stays high. A programmed blanking of 0 behaves as 1.
- R3: After a frame ends normally, frameValid is low for cfgHBlank + cfgVBlank*(W + cfgHBlank) + 1 cycles. frameValid rises in the same cycle as the first lineValid of a frame.
- R4: A frame delivers H = (cfgRowSize with bit 0 forced to 1) + 1 lines of W pixels each, in raster order. Row addresses start at cfgRowStart with bit 0 cleared, and column addresses start at cfgColStart with bit 0 cleared.
- R5: bayerPhase = {row address bit 0, column address bit 0}. The codes are 0 GreenR, 1 Red, 2 Blue, 3 GreenB.
- R6: cfgMirrorRow reverses the order of rows within the window. cfgMirrorCol reverses the order of columns within each line. The colour phase follows the mirrored address.
- R7: A one-cycle restartReq sets restartBusy on the next cycle. The row in progress and one more row then complete, including their blanking. frameValid is low for exactly one cycle, and a new frame starts from its first row. restartBusy is low by the time that frame's first pixel appears.
- R8: If pauseRestart is high when a restart completes, frameValid and lineValid stay low and restartBusy stays high until pauseRestart falls. The first pixel then appears on the third cycle after the cycle in which pauseRestart is seen low.
- R9: Changing any cfg input during a frame has no effect on that frame. The new values apply from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-slot clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgColStart | input | COL_W | First column of the window (bit 0 ignored) |
| cfgRowStart | input | ROW_W | First row of the window (bit 0 ignored) |
| cfgColSize | input | COL_W | Window width minus one (bit 0 forced to 1) |
| cfgRowSize | input | ROW_W | Window height minus one (bit 0 forced to 1) |
| cfgHBlank | input | BLK_W | Horizontal blanking in cycles |
| cfgVBlank | input | BLK_W | Vertical blanking in row periods |
| cfgMirrorRow | input | 1 | Reverse row order |
| cfgMirrorCol | input | 1 | Reverse column order |
| restartReq | input | 1 | One-cycle restart request |
| pauseRestart | input | 1 | Hold at frame start after a restart |
| frameValid | output | 1 | High from first to last pixel of a frame |
| lineValid | output | 1 | High during active pixels |
| rowAddr | output | ROW_W | Array row of the current pixel |
| colAddr | output | COL_W | Array column of the current pixel |
| bayerPhase | output | 2 | Colour phase of the current pixel |
| restartBusy | output | 1 | Restart requested and not yet applied |

## Verification
A bad row or column counter shows up within one line period, either as a line-valid run of the wrong length or as an address out of sequence. The per-pixel scoreboard reports the first wrong pixel address or colour phase as soon as it leaves the block. A wrong restart or pause state appears at the next row end, as a blanking gap of the wrong length or a frame that does not start. Geometry latched at the wrong moment corrupts the frame in progress, and the scoreboard catches it on the next pixel.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  // Window used until the first frame load
  localparam int DEF_COL_START = 16;
  localparam int DEF_ROW_START = 60;
  localparam int DEF_WIDTH     = 1440;
  localparam int DEF_HEIGHT    = 1080;

  typedef enum logic [1:0] {
    SEQ_LOAD  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_PAUSE = 2'd2
  } seqState_t;

  // Strobes from sequencer to geometry datapath
  typedef struct packed {
    logic loadCfg;
    logic pixValid;
    logic frameOn;
  } seqStrobe_t;

endpackage

// File: rtl/rwin_seq.sv
module rwin_seq
  import rwin_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restartReq,
  input  logic             pauseHold,
  input  logic [CNT_W-1:0] actW,
  input  logic [CNT_W-1:0] actH,
  input  logic [CNT_W-1:0] rowPeriod,
  input  logic [CNT_W-1:0] frameRows,
  output seqStrobe_t       strobe,
  output logic [CNT_W-1:0] colIdx,
  output logic [CNT_W-1:0] rowIdx,
  output logic             restartBusy
);

  seqState_t  state, stateNext;
  logic [CNT_W-1:0] colCnt, rowCnt;
  logic pending, rowsSeen;
  logic rowEnd, lastRow, restartDone, frameDone, clrPend;
  logic inRun, activeRow;

  always_comb begin
    inRun       = (state == SEQ_RUN);
    rowEnd      = inRun && (colCnt == rowPeriod - CNT_W'(1));
    lastRow     = (rowCnt == frameRows - CNT_W'(1));
    restartDone = pending && rowEnd && (rowsSeen || lastRow);
    frameDone   = (rowEnd && lastRow) || restartDone;
    clrPend     = (inRun && restartDone && !pauseHold) ||
                  ((state == SEQ_PAUSE) && !pauseHold);
    activeRow   = rowCnt < actH;

    stateNext = state;
    unique case (state)
      SEQ_LOAD:  stateNext = SEQ_RUN;
      SEQ_RUN: begin
        if (restartDone && pauseHold) stateNext = SEQ_PAUSE;
        else if (frameDone)           stateNext = SEQ_LOAD;
      end
      SEQ_PAUSE: if (!pauseHold) stateNext = SEQ_LOAD;
      default:   stateNext = SEQ_LOAD;
    endcase

    strobe.loadCfg  = (state == SEQ_LOAD);
    strobe.pixValid = inRun && activeRow && (colCnt < actW);
    strobe.frameOn  = inRun && activeRow &&
                      !((rowCnt == actH - CNT_W'(1)) && (colCnt >= actW));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_LOAD;
      colCnt   <= '0;
      rowCnt   <= '0;
      pending  <= 1'b0;
      rowsSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (inRun && !frameDone) begin
        if (rowEnd) begin
          colCnt <= '0;
          rowCnt <= rowCnt + CNT_W'(1);
        end else begin
          colCnt <= colCnt + CNT_W'(1);
        end
      end else begin
        colCnt <= '0;
        rowCnt <= '0;
      end
      // A new request wins over a completion in the same cycle
      if (restartReq)   pending <= 1'b1;
      else if (clrPend) pending <= 1'b0;
      if (restartDone || !pending) rowsSeen <= 1'b0;
      else if (rowEnd)             rowsSeen <= 1'b1;
    end
  end

  assign colIdx      = colCnt;
  assign rowIdx      = rowCnt;
  assign restartBusy = pending;

endmodule

// File: rtl/rwin_geom.sv
module rwin_geom
  import rwin_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 11,
  parameter int BLK_W = 12,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] cfgColStart,
  input  logic [ROW_W-1:0] cfgRowStart,
  input  logic [COL_W-1:0] cfgColSize,
  input  logic [ROW_W-1:0] cfgRowSize,
  input  logic [BLK_W-1:0] cfgHBlank,
  input  logic [BLK_W-1:0] cfgVBlank,
  input  logic             cfgMirrorRow,
  input  logic             cfgMirrorCol,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] colIdx,
  input  logic [CNT_W-1:0] rowIdx,
  output logic [CNT_W-1:0] actW,
  output logic [CNT_W-1:0] actH,
  output logic [CNT_W-1:0] rowPeriod,
  output logic [CNT_W-1:0] frameRows,
  output logic             frameValid,
  output logic             lineValid,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic [1:0]       bayerPhase
);

  localparam logic [COL_W-1:0] COL_EVEN = {{(COL_W-1){1'b1}}, 1'b0};
  localparam logic [ROW_W-1:0] ROW_EVEN = {{(ROW_W-1){1'b1}}, 1'b0};
  localparam logic [COL_W-1:0] COL_ODD  = {{(COL_W-1){1'b0}}, 1'b1};
  localparam logic [ROW_W-1:0] ROW_ODD  = {{(ROW_W-1){1'b0}}, 1'b1};

  logic [COL_W-1:0] shColStart;
  logic [ROW_W-1:0] shRowStart;
  logic [CNT_W-1:0] shW, shH;
  logic [BLK_W-1:0] shHb, shVb;
  logic             shMirR, shMirC;
  logic [CNT_W-1:0] colOff, rowOff;
  logic [COL_W-1:0] colAddrNext;
  logic [ROW_W-1:0] rowAddrNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shColStart <= COL_W'(DEF_COL_START);
      shRowStart <= ROW_W'(DEF_ROW_START);
      shW        <= CNT_W'(DEF_WIDTH);
      shH        <= CNT_W'(DEF_HEIGHT);
      shHb       <= BLK_W'(1);
      shVb       <= '0;
      shMirR     <= 1'b0;
      shMirC     <= 1'b0;
    end else if (strobe.loadCfg) begin
      shColStart <= cfgColStart & COL_EVEN;
      shRowStart <= cfgRowStart & ROW_EVEN;
      shW        <= CNT_W'(cfgColSize | COL_ODD) + CNT_W'(1);
      shH        <= CNT_W'(cfgRowSize | ROW_ODD) + CNT_W'(1);
      shHb       <= (cfgHBlank == '0) ? BLK_W'(1) : cfgHBlank;
      shVb       <= cfgVBlank;
      shMirR     <= cfgMirrorRow;
      shMirC     <= cfgMirrorCol;
    end
  end

  always_comb begin
    actW      = shW;
    actH      = shH;
    rowPeriod = shW + CNT_W'(shHb);
    frameRows = shH + CNT_W'(shVb);
    colOff    = shMirC ? (shW - CNT_W'(1) - colIdx) : colIdx;
    rowOff    = shMirR ? (shH - CNT_W'(1) - rowIdx) : rowIdx;
    colAddrNext = COL_W'(CNT_W'(shColStart) + colOff);
    rowAddrNext = ROW_W'(CNT_W'(shRowStart) + rowOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      lineValid  <= 1'b0;
      rowAddr    <= '0;
      colAddr    <= '0;
      bayerPhase <= 2'd0;
    end else begin
      frameValid <= strobe.frameOn;
      lineValid  <= strobe.pixValid;
      if (strobe.pixValid) begin
        rowAddr    <= rowAddrNext;
        colAddr    <= colAddrNext;
        bayerPhase <= {rowAddrNext[0], colAddrNext[0]};
      end
    end
  end

endmodule

// File: rtl/rwin_timing.sv
module rwin_timing
  import rwin_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int ROW_W = 11,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] cfgColStart,
  input  logic [ROW_W-1:0] cfgRowStart,
  input  logic [COL_W-1:0] cfgColSize,
  input  logic [ROW_W-1:0] cfgRowSize,
  input  logic [BLK_W-1:0] cfgHBlank,
  input  logic [BLK_W-1:0] cfgVBlank,
  input  logic             cfgMirrorRow,
  input  logic             cfgMirrorCol,
  input  logic             restartReq,
  input  logic             pauseRestart,
  output logic             frameValid,
  output logic             lineValid,
  output logic [ROW_W-1:0] rowAddr,
  output logic [COL_W-1:0] colAddr,
  output logic [1:0]       bayerPhase,
  output logic             restartBusy
);

  localparam int DIM_W = (COL_W > ROW_W) ? COL_W : ROW_W;
  localparam int CNT_W = ((DIM_W > BLK_W) ? DIM_W : BLK_W) + 2;

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] colIdx, rowIdx, actW, actH, rowPeriod, frameRows;

  rwin_seq #(.CNT_W(CNT_W)) uSeq (
    .clk(clk), .rstN(rstN),
    .restartReq(restartReq), .pauseHold(pauseRestart),
    .actW(actW), .actH(actH), .rowPeriod(rowPeriod), .frameRows(frameRows),
    .strobe(strobe), .colIdx(colIdx), .rowIdx(rowIdx),
    .restartBusy(restartBusy)
  );

  rwin_geom #(.COL_W(COL_W), .ROW_W(ROW_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) uGeom (
    .clk(clk), .rstN(rstN),
    .cfgColStart(cfgColStart), .cfgRowStart(cfgRowStart),
    .cfgColSize(cfgColSize), .cfgRowSize(cfgRowSize),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank),
    .cfgMirrorRow(cfgMirrorRow), .cfgMirrorCol(cfgMirrorCol),
    .strobe(strobe), .colIdx(colIdx), .rowIdx(rowIdx),
    .actW(actW), .actH(actH), .rowPeriod(rowPeriod), .frameRows(frameRows),
    .frameValid(frameValid), .lineValid(lineValid),
    .rowAddr(rowAddr), .colAddr(colAddr), .bayerPhase(bayerPhase)
  );

endmodule

// File: rtl/rwin_timing_chk.sv
module rwin_timing_chk #(
  parameter int COL_W = 11,
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic             lineValid,
  input logic [ROW_W-1:0] rowAddr,
  input logic [COL_W-1:0] colAddr,
  input logic [1:0]       bayerPhase,
  input logic             restartReq,
  input logic             restartBusy
);

  // R2
  a_r2_lv_inside_fv: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> frameValid);

  // R3
  a_r3_fv_rises_with_lv: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameValid) |-> lineValid);

  // R4: within a line the row holds and the column moves by one
  a_r4_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && $past(lineValid)) |->
      ((rowAddr == $past(rowAddr)) &&
       (((colAddr - $past(colAddr)) == COL_W'(1)) ||
        (($past(colAddr) - colAddr) == COL_W'(1)))));

  // R5: adjacent pixels of a line differ in column parity only
  a_r5_phase_alternates: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && $past(lineValid)) |->
      ((bayerPhase[0] != $past(bayerPhase[0])) &&
       (bayerPhase[1] == $past(bayerPhase[1]))));

  // R7
  a_r7_req_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> restartBusy);

endmodule

bind rwin_timing rwin_timing_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) uChk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .lineValid(lineValid),
  .rowAddr(rowAddr), .colAddr(colAddr), .bayerPhase(bayerPhase),
  .restartReq(restartReq), .restartBusy(restartBusy)
);

// File: tb/rwin_timing_test.sv
module rwin_timing_test;

  localparam int COL_W = 11;
  localparam int ROW_W = 11;
  localparam int BLK_W = 12;

  logic clk = 1'b0;
  logic rstN;
  logic [COL_W-1:0] cfgColStart, cfgColSize;
  logic [ROW_W-1:0] cfgRowStart, cfgRowSize;
  logic [BLK_W-1:0] cfgHBlank, cfgVBlank;
  logic cfgMirrorRow, cfgMirrorCol, restartReq, pauseRestart;
  logic frameValid, lineValid, restartBusy;
  logic [ROW_W-1:0] rowAddr;
  logic [COL_W-1:0] colAddr;
  logic [1:0] bayerPhase;

  int checks = 0;
  int errors = 0;
  bit monActive = 1'b1;
  bit finished = 1'b0;
  logic [24:0] expQ[$];

  always #4 clk = ~clk;

  rwin_timing #(.COL_W(COL_W), .ROW_W(ROW_W), .BLK_W(BLK_W)) uut (
    .clk(clk), .rstN(rstN),
    .cfgColStart(cfgColStart), .cfgRowStart(cfgRowStart),
    .cfgColSize(cfgColSize), .cfgRowSize(cfgRowSize),
    .cfgHBlank(cfgHBlank), .cfgVBlank(cfgVBlank),
    .cfgMirrorRow(cfgMirrorRow), .cfgMirrorCol(cfgMirrorCol),
    .restartReq(restartReq), .pauseRestart(pauseRestart),
    .frameValid(frameValid), .lineValid(lineValid),
    .rowAddr(rowAddr), .colAddr(colAddr), .bayerPhase(bayerPhase),
    .restartBusy(restartBusy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: queue the pixels one frame should produce
  task automatic pushFrame(input int cs, input int rs, input int w, input int h,
                           input bit mr, input bit mc, input int rowsOut);
    for (int r = 0; r < rowsOut; r++) begin
      for (int c = 0; c < w; c++) begin
        int ra;
        int ca;
        logic [10:0] ra11;
        logic [10:0] ca11;
        ra = mr ? (rs + h - 1 - r) : (rs + r);
        ca = mc ? (cs + w - 1 - c) : (cs + c);
        ra11 = ra[10:0];
        ca11 = ca[10:0];
        expQ.push_back({(mr | mc), ra11, ca11, ra11[0], ca11[0]});
      end
    end
  endtask

  // Monitor: compare each delivered pixel with the scoreboard
  always @(negedge clk) begin
    if (monActive && rstN && lineValid) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R4: actual extra pixel row %0d col %0d expected none", rowAddr, colAddr);
      end else begin
        logic [24:0] it;
        it = expQ.pop_front();
        check(it[24] ? "R6 row" : "R4 row", int'(rowAddr), int'(it[23:13]));
        check(it[24] ? "R6 col" : "R4 col", int'(colAddr), int'(it[12:2]));
        check("R5 phase", int'(bayerPhase), int'(it[1:0]));
      end
    end
  end

  task automatic waitRise();
    @(negedge clk);
    while (!frameValid) @(negedge clk);
  endtask

  task automatic lvRun(output int n);
    n = 0;
    while (lineValid) begin n++; @(negedge clk); end
  endtask

  task automatic hbRun(output int n);
    n = 0;
    while (!lineValid && frameValid) begin n++; @(negedge clk); end
  endtask

  task automatic gapRun(output int n);
    while (frameValid) @(negedge clk);
    n = 0;
    while (!frameValid) begin n++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int n;
    bit ok;
    rstN = 1'b0;
    restartReq = 1'b0;
    pauseRestart = 1'b0;
    // Config A: origin (16,60), 8x4, hb 3, vb 2
    cfgColStart = 11'd16; cfgRowStart = 11'd60;
    cfgColSize = 11'd7; cfgRowSize = 11'd3;
    cfgHBlank = 12'd3; cfgVBlank = 12'd2;
    cfgMirrorRow = 1'b0; cfgMirrorCol = 1'b0;

    pushFrame(16, 60, 8, 4, 1'b0, 1'b0, 4);  // frame 1, A
    pushFrame(4, 2, 6, 4, 1'b1, 1'b1, 4);    // frame 2, B
    pushFrame(0, 0, 4, 6, 1'b1, 1'b0, 6);    // frame 3, C
    pushFrame(0, 0, 4, 6, 1'b1, 1'b0, 2);    // frame 4, cut by restart
    pushFrame(0, 0, 4, 6, 1'b1, 1'b0, 2);    // frame 5, cut, then pause
    pushFrame(0, 0, 4, 6, 1'b1, 1'b0, 6);    // frame 6

    repeat (3) @(negedge clk);
    check("R1 frameValid", int'(frameValid), 0);
    check("R1 lineValid", int'(lineValid), 0);
    check("R1 restartBusy", int'(restartBusy), 0);
    rstN = 1'b1;

    waitRise();
    lvRun(n);  check("R2 line width A", n, 8);
    hbRun(n);  check("R3 hblank A", n, 3);
    // Mid-frame change to config B: odd start and even size, both mirrors
    cfgColStart = 11'd5; cfgRowStart = 11'd3;
    cfgColSize = 11'd4; cfgRowSize = 11'd2;
    cfgHBlank = 12'd2; cfgVBlank = 12'd1;
    cfgMirrorRow = 1'b1; cfgMirrorCol = 1'b1;
    check("R9 row kept", int'(rowAddr), 61);
    check("R9 col kept", int'(colAddr), 16);
    lvRun(n);  check("R9 width kept", n, 8);
    gapRun(n); check("R3 vblank gap A", n, 3 + 2 * (8 + 3) + 1);

    // Frame 2 (B) now running; queue config C for later frames
    cfgColStart = 11'd0; cfgRowStart = 11'd0;
    cfgColSize = 11'd3; cfgRowSize = 11'd5;
    cfgHBlank = 12'd2; cfgVBlank = 12'd0;
    cfgMirrorRow = 1'b1; cfgMirrorCol = 1'b0;
    lvRun(n);  check("R4 forced width B", n, 6);
    gapRun(n); check("R3 vblank gap B", n, 2 + 1 * (6 + 2) + 1);
    gapRun(n); check("R3 gap with zero vblank", n, 2 + 1);

    // Frame 4: restart during the first pixel of row 0
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    check("R7 busy set", int'(restartBusy), 1);
    gapRun(n); check("R7 restart gap", n, 1);
    check("R7 busy cleared", int'(restartBusy), 0);

    // Frame 5: restart with pause held
    pauseRestart = 1'b1;
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    while (frameValid) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (frameValid || lineValid || !restartBusy) ok = 1'b0;
      @(negedge clk);
    end
    check("R8 held while paused", int'(ok), 1);
    pauseRestart = 1'b0;
    n = 0;
    while (!frameValid) begin n++; @(negedge clk); end
    check("R8 release latency", n, 3);
    check("R8 busy cleared", int'(restartBusy), 0);

    while (frameValid) @(negedge clk);
    monActive = 1'b0;
    check("R4 all pixels delivered", expQ.size(), 0);
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule